// File: doc/BRIEF.md
# Delay line calibration sequencer

This block finds how many unit delays of a tapped delay line add up to one period of the input clock. Firmware would otherwise do this with a polling loop. The block raises a sampling-enable output, holds the phase select at its top value, and steps the unit setting upward from zero. After each step it waits for the delay line's length-valid flag and then judges the 12-bit length sample that comes back.

The first sample that shows exactly one clock period stops the sweep. The phase count is then taken from the highest set bit of that sample, and the block reports it together with the unit setting that produced it. The sweep can also end in an error (no usable sample, or no usable bit position) or in a timeout (the valid flag never came).

A second request, the direct apply, loads a given select and unit pair with the same sampling-enable handshake around it. It does not search.

The timeout is counted in ticks from an external prescaler enable, so its length in time does not depend on the core clock.

Top module: `dlcal_seq`

## Requirements
- R1: Sampling enable (`samp_en_o`) is already high in the cycle before the select/unit outputs change and stays high while they change. It falls in the same cycle that `done_o` pulses.
- R2: During calibration `sel_o` is held at `MAX_SEL` (default 11). `unit_o` takes the values 0, 1, 2, … in order, one value per attempt.
- R3: After each new unit setting the block waits for `len_valid_i`, counting only cycles with `tick_i` high. If `len_valid_i` is still low when the `TMO_TICKS`-th tick (default 255) arrives, the run ends with `tmo_o`=1. A `len_valid_i` that is high in the same cycle as that tick is still used.
- R4: A sample is accepted when bits 10..0 of `len_i` are not all zero and bits 11 and 10 are not both one. Acceptance ends the sweep.
- R5: If no sample is accepted after all 2^`UNIT_W` unit settings (0 to 127 by default) have been tried, the run ends with `err_o`=1.
- R6: For an accepted sample, the phase count is the index of the highest set bit within `len_i[10:1]`. If none of those bits is set, the run ends with `err_o`=1.
- R7: On success `ok_o`=1, `res_sel_o` equals that bit index and `res_unit_o` equals the accepted unit setting.
- R8: An `apply_i` pulse in idle captures `apply_sel_i`/`apply_unit_i`, raises sampling enable, drives the pair onto `sel_o`/`unit_o`, and then releases the enable. It completes with `ok_o`=1, and `res_sel_o`/`res_unit_o` show the applied pair.
- R9: `cal_start_i` or `apply_i` while `busy_o` is high has no effect. The running calibration keeps its sweep order and produces exactly one result.
- R10: `done_o` is a one-cycle pulse. At that pulse exactly one of `ok_o`, `err_o`, `tmo_o` is high. The status and result outputs hold until the next accepted request. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timeout prescaler enable, one tick per high cycle |
| cal_start_i | input | 1 | Start a calibration sweep (taken in idle only) |
| apply_i | input | 1 | Load a given select/unit pair (taken in idle only) |
| apply_sel_i | input | SEL_W | Select value for a direct apply |
| apply_unit_i | input | UNIT_W | Unit value for a direct apply |
| len_i | input | LEN_W | Length sample from the delay line |
| len_valid_i | input | 1 | Length sample valid for the current setting |
| samp_en_o | output | 1 | Sampling enable to the delay line |
| sel_o | output | SEL_W | Phase select driven to the delay line |
| unit_o | output | UNIT_W | Unit delay setting driven to the delay line |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last request succeeded |
| err_o | output | 1 | Last calibration found no usable sample |
| tmo_o | output | 1 | Last calibration timed out waiting for valid |
| res_sel_o | output | SEL_W | Detected phase count or applied select |
| res_unit_o | output | UNIT_W | Accepted unit setting or applied unit |

## Verification
The bench builds the block with its default parameters: a 7-bit unit field, a 4-bit select with a top value of 11, a 12-bit sample and a 255-tick timeout. With a 7-bit unit field the full sweep is only 128 settings, so the bench can run it to exhaustion and see the error end every setting. With a 255-tick timeout the bench can place the valid flag exactly on the last tick and exactly one cycle after it, which checks the final look at the flag at the timeout instant. A prescaler divide of three shows that the timeout scales with the tick rate and not with the core clock.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;

    // Sequencer phases, shared by the top and its checks
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_CAL_SET = 3'd1,
        S_GUARD   = 3'd2,
        S_WAIT    = 3'd3,
        S_APPLY   = 3'd4,
        S_REL     = 3'd5
    } dlcal_state_e;

endpackage

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
    parameter int TMO_TICKS = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);

    localparam int TW = $clog2(TMO_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (run_i && tick_i && (r_q.cnt != LAST)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // the final tick of the window is the one seen while the count sits at LAST
    assign expired_o = run_i && tick_i && (r_q.cnt == LAST);

    // R3: the tick count never leaves the timeout window
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);

    // R3: every new unit setting starts a fresh window
    a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (r_q.cnt == '0));

endmodule

// File: rtl/dlcal_len_eval.sv
module dlcal_len_eval #(
    parameter int LEN_W = 12,
    parameter int SEL_W = 4
) (
    input  logic [LEN_W-1:0] len_i,
    output logic             accept_o,
    output logic             found_o,
    output logic [SEL_W-1:0] pos_o
);

    localparam int TOP  = LEN_W - 1;
    localparam int NEXT = LEN_W - 2;

    // one period seen: some tap below the top one is set, yet not both top taps
    assign accept_o = (|len_i[NEXT:0]) && !(len_i[TOP] && len_i[NEXT]);

    // highest set tap within [NEXT:1]; ascending scan lets the last hit win
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int i = 1; i <= NEXT; i++) begin
            if (len_i[i]) begin
                found_o = 1'b1;
                pos_o   = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/dlcal_seq.sv
module dlcal_seq
    import dlcal_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int UNIT_W    = 7,
    parameter int LEN_W     = 12,
    parameter int MAX_SEL   = 11,
    parameter int TMO_TICKS = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cal_start_i,
    input  logic              apply_i,
    input  logic [SEL_W-1:0]  apply_sel_i,
    input  logic [UNIT_W-1:0] apply_unit_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              len_valid_i,
    output logic              samp_en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [UNIT_W-1:0] unit_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic              err_o,
    output logic              tmo_o,
    output logic [SEL_W-1:0]  res_sel_o,
    output logic [UNIT_W-1:0] res_unit_o
);

    localparam logic [SEL_W-1:0]  SEL_TOP   = SEL_W'(MAX_SEL);
    localparam logic [UNIT_W-1:0] UNIT_LAST = '1;

    typedef struct packed {
        dlcal_state_e      st;
        logic              samp_en;
        logic [SEL_W-1:0]  sel;
        logic [UNIT_W-1:0] unit;
        logic [UNIT_W-1:0] cnt;
        logic [SEL_W-1:0]  pend_sel;
        logic [UNIT_W-1:0] pend_unit;
        logic              done;
        logic              ok;
        logic              err;
        logic              tmo;
        logic [SEL_W-1:0]  res_sel;
        logic [UNIT_W-1:0] res_unit;
    } seq_t;

    seq_t r_d, r_q;

    logic             tmr_clr;
    logic             tmr_run;
    logic             expired;
    logic             accept;
    logic             found;
    logic [SEL_W-1:0] pos;

    dlcal_timer #(
        .TMO_TICKS (TMO_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .tick_i    (tick_i),
        .expired_o (expired)
    );

    dlcal_len_eval #(
        .LEN_W (LEN_W),
        .SEL_W (SEL_W)
    ) u_eval (
        .len_i    (len_i),
        .accept_o (accept),
        .found_o  (found),
        .pos_o    (pos)
    );

    assign tmr_run = (r_q.st == S_GUARD) || (r_q.st == S_WAIT);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_clr  = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cal_start_i) begin
                    r_d.samp_en = 1'b1;
                    r_d.cnt     = '0;
                    r_d.ok      = 1'b0;
                    r_d.err     = 1'b0;
                    r_d.tmo     = 1'b0;
                    r_d.st      = S_CAL_SET;
                end else if (apply_i) begin
                    r_d.samp_en   = 1'b1;
                    r_d.pend_sel  = apply_sel_i;
                    r_d.pend_unit = apply_unit_i;
                    r_d.ok        = 1'b0;
                    r_d.err       = 1'b0;
                    r_d.tmo       = 1'b0;
                    r_d.st        = S_APPLY;
                end
            end
            S_CAL_SET: begin
                r_d.sel  = SEL_TOP;
                r_d.unit = r_q.cnt;
                tmr_clr  = 1'b1;
                r_d.st   = S_GUARD;
            end
            S_GUARD: begin
                // valid may still describe the previous setting: skip this cycle
                r_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (len_valid_i) begin
                    if (accept) begin
                        if (found) begin
                            r_d.ok       = 1'b1;
                            r_d.res_sel  = pos;
                            r_d.res_unit = r_q.unit;
                        end else begin
                            r_d.err = 1'b1;
                        end
                        r_d.st = S_REL;
                    end else if (r_q.cnt == UNIT_LAST) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_REL;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.st  = S_CAL_SET;
                    end
                end else if (expired) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = S_REL;
                end
            end
            S_APPLY: begin
                r_d.sel      = r_q.pend_sel;
                r_d.unit     = r_q.pend_unit;
                r_d.ok       = 1'b1;
                r_d.res_sel  = r_q.pend_sel;
                r_d.res_unit = r_q.pend_unit;
                r_d.st       = S_REL;
            end
            S_REL: begin
                r_d.samp_en = 1'b0;
                r_d.done    = 1'b1;
                r_d.st      = S_IDLE;
            end
            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign samp_en_o  = r_q.samp_en;
    assign sel_o      = r_q.sel;
    assign unit_o     = r_q.unit;
    assign busy_o     = (r_q.st != S_IDLE);
    assign done_o     = r_q.done;
    assign ok_o       = r_q.ok;
    assign err_o      = r_q.err;
    assign tmo_o      = r_q.tmo;
    assign res_sel_o  = r_q.res_sel;
    assign res_unit_o = r_q.res_unit;

    // R1: configuration moves only inside an enable window
    a_r1_cfg_under_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({r_q.sel, r_q.unit}) |-> (r_q.samp_en && $past(r_q.samp_en)));

    // R1: the enable is dropped only together with completion
    a_r1_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.samp_en) |-> r_q.done);

    // R2: the select sits at its top value while a sample is awaited
    a_r2_sel_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> (r_q.sel == SEL_TOP));

    // R2: a retry moves the unit setting up by exactly one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_GUARD) && ($past(r_q.st) == S_CAL_SET) && ($past(r_q.st, 2) == S_WAIT))
        |-> (r_q.unit == UNIT_W'($past(r_q.unit, 2) + 1'b1)));

    // R9: a start while a sample is awaited does not return to idle
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && cal_start_i) |=> (r_q.st != S_IDLE));

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R10: exactly one outcome is reported at completion
    a_r10_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> $onehot({r_q.ok, r_q.err, r_q.tmo}));

    // R10: outcome holds in idle until a new request is taken
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_IDLE) && !cal_start_i && !apply_i)
        |=> $stable({r_q.ok, r_q.err, r_q.tmo, r_q.res_sel, r_q.res_unit}));

endmodule

// File: tb/test_dlcal_seq.sv
module test_dlcal_seq;

    localparam int SEL_W     = 4;
    localparam int UNIT_W    = 7;
    localparam int LEN_W     = 12;
    localparam int MAX_SEL   = 11;
    localparam int TMO_TICKS = 255;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b1;
    logic              cal_start_i = 1'b0;
    logic              apply_i = 1'b0;
    logic [SEL_W-1:0]  apply_sel_i = '0;
    logic [UNIT_W-1:0] apply_unit_i = '0;
    logic [LEN_W-1:0]  len_i = '0;
    logic              len_valid_i = 1'b0;
    logic              samp_en_o;
    logic [SEL_W-1:0]  sel_o;
    logic [UNIT_W-1:0] unit_o;
    logic              busy_o, done_o, ok_o, err_o, tmo_o;
    logic [SEL_W-1:0]  res_sel_o;
    logic [UNIT_W-1:0] res_unit_o;

    always #2 clk = ~clk;   // 250 MHz

    dlcal_seq #(
        .SEL_W (SEL_W), .UNIT_W (UNIT_W), .LEN_W (LEN_W),
        .MAX_SEL (MAX_SEL), .TMO_TICKS (TMO_TICKS)
    ) i_dlcal_seq (
        .clk (clk), .rst_n (rst_n), .tick_i (tick_i),
        .cal_start_i (cal_start_i), .apply_i (apply_i),
        .apply_sel_i (apply_sel_i), .apply_unit_i (apply_unit_i),
        .len_i (len_i), .len_valid_i (len_valid_i),
        .samp_en_o (samp_en_o), .sel_o (sel_o), .unit_o (unit_o),
        .busy_o (busy_o), .done_o (done_o), .ok_o (ok_o), .err_o (err_o),
        .tmo_o (tmo_o), .res_sel_o (res_sel_o), .res_unit_o (res_unit_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    typedef struct {
        logic  ok;
        logic  err;
        logic  tmo;
        int    sel;
        int    unit;
        string req;
    } exp_t;

    exp_t sb_q[$];

    // delay line stand-in controls
    int           tgt_unit = 0;
    logic [11:0]  rej0 = 12'h000;
    logic [11:0]  rej1 = 12'hC01;
    logic [11:0]  acc_pat = 12'h000;
    int           lat = 1;
    int           tick_div = 1;
    int           tdiv_cnt = 0;
    bit           cal_mode = 1'b0;

    int vcnt = 0;
    int prev_sel = 0, prev_unit = 0;
    bit prev_en = 1'b0;
    int viol_en = 0, viol_sel = 0, viol_step = 0;
    int done_cnt = 0;

    function automatic logic [11:0] pattern(input int u);
        if (u < tgt_unit) return (u % 2 == 1) ? rej1 : rej0;
        return acc_pat;
    endfunction

    // prescaler enable
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick_i <= 1'b1;
        end else begin
            tdiv_cnt = (tdiv_cnt + 1) % tick_div;
            tick_i <= (tdiv_cnt == 0);
        end
    end

    // delay line stand-in, configuration-order monitor and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if ((int'(sel_o) != prev_sel) || (int'(unit_o) != prev_unit)) begin
                if (!samp_en_o || !prev_en) viol_en++;
                if (cal_mode) begin
                    if (int'(sel_o) != MAX_SEL) viol_sel++;
                    if ((int'(unit_o) != 0) && (int'(unit_o) != prev_unit + 1)) viol_step++;
                end
                vcnt = lat;
                len_valid_i <= 1'b0;
            end else if (vcnt != 0) begin
                if (vcnt == 1) len_valid_i <= 1'b1;
                vcnt--;
            end
            len_i <= pattern(int'(unit_o));

            if (done_o) begin
                done_cnt++;
                chk(!samp_en_o && prev_en, "R1", "enable release at done",
                    int'(samp_en_o), 0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk({ok_o, err_o, tmo_o} == {e.ok, e.err, e.tmo}, e.req,
                        "status ok/err/tmo", int'({ok_o, err_o, tmo_o}),
                        int'({e.ok, e.err, e.tmo}));
                    if (e.ok) begin
                        chk(int'(res_sel_o) == e.sel, e.req, "result select",
                            int'(res_sel_o), e.sel);
                        chk(int'(res_unit_o) == e.unit, e.req, "result unit",
                            int'(res_unit_o), e.unit);
                    end
                end
            end
            prev_sel  = int'(sel_o);
            prev_unit = int'(unit_o);
            prev_en   = samp_en_o;
        end
    end

    task automatic wait_empty();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_apply(input int s, input int u, input string req);
        exp_t e;
        e = '{ok: 1'b1, err: 1'b0, tmo: 1'b0, sel: s, unit: u, req: req};
        sb_q.push_back(e);
        @(negedge clk);
        apply_i      = 1'b1;
        apply_sel_i  = SEL_W'(s);
        apply_unit_i = UNIT_W'(u);
        @(negedge clk);
        apply_i = 1'b0;
        wait_empty();
    endtask

    task automatic run_cal(input int tgt, input logic [11:0] acc, input int l,
                           input logic eok, input logic eerr, input logic etmo,
                           input int esel, input int eunit, input string req);
        exp_t e;
        do_apply(0, 0, "R8");          // park away from the sweep start
        tgt_unit = tgt;
        acc_pat  = acc;
        lat      = l;
        cal_mode = 1'b1;
        e = '{ok: eok, err: eerr, tmo: etmo, sel: esel, unit: eunit, req: req};
        sb_q.push_back(e);
        @(negedge clk);
        cal_start_i = 1'b1;
        @(negedge clk);
        cal_start_i = 1'b0;
        wait_empty();
        cal_mode = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R10", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        int dcnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk({samp_en_o, busy_o, done_o, ok_o, err_o, tmo_o} == 6'b0, "R10",
            "reset control outputs",
            int'({samp_en_o, busy_o, done_o, ok_o, err_o, tmo_o}), 0);
        chk((sel_o == '0) && (unit_o == '0) && (res_sel_o == '0) && (res_unit_o == '0),
            "R10", "reset data outputs", int'(unit_o), 0);

        // R2 R4 R7: rejects at units 0..4, accept 0x0A4 at unit 5 -> select 7
        run_cal(5, 12'h0A4, 3, 1'b1, 1'b0, 1'b0, 7, 5, "R7");
        repeat (5) @(negedge clk);
        chk(ok_o && !err_o && (res_sel_o == 4'd7) && (res_unit_o == 7'd5), "R10",
            "status held after done", int'(res_sel_o), 7);

        // R6: bit 10 is the highest searched position
        run_cal(0, 12'h400, 2, 1'b1, 1'b0, 1'b0, 10, 0, "R6");
        // R6: accepted but only bit 0 set -> error
        run_cal(2, 12'h001, 2, 1'b0, 1'b1, 1'b0, 0, 0, "R6");
        // R4: bit 11 set with bit 10 clear still accepts; bit 1 -> select 1
        run_cal(1, 12'h802, 4, 1'b1, 1'b0, 1'b0, 1, 1, "R4");
        // R5: nothing ever accepted -> error after the whole sweep
        run_cal(1000, 12'h000, 2, 1'b0, 1'b1, 1'b0, 0, 0, "R5");
        chk(int'(unit_o) == 127, "R5", "last unit tried", int'(unit_o), 127);

        // R3: valid lands on the final tick -> still used
        run_cal(0, 12'h010, 254, 1'b1, 1'b0, 1'b0, 4, 0, "R3");
        // R3: valid one cycle late -> timeout
        run_cal(0, 12'h010, 255, 1'b0, 1'b0, 1'b1, 0, 0, "R3");

        // R3: timeout measured in prescaler ticks (one tick every 3 cycles)
        tick_div = 3;
        do_apply(0, 0, "R8");
        tgt_unit = 0; lat = 0; cal_mode = 1'b1;
        sb_q.push_back('{ok: 1'b0, err: 1'b0, tmo: 1'b1, sel: 0, unit: 0, req: "R3"});
        @(negedge clk);
        cal_start_i = 1'b1;
        t0 = 0;
        @(negedge clk);
        cal_start_i = 1'b0;
        while (!done_o) begin
            @(negedge clk);
            t0++;
        end
        chk((t0 >= 762) && (t0 <= 775), "R3", "cycles to timeout at divide 3", t0, 766);
        wait_empty();
        cal_mode = 1'b0;
        tick_div = 1;

        // R8: direct apply drives the pair
        do_apply(3, 17, "R8");
        chk((sel_o == 4'd3) && (unit_o == 7'd17), "R8", "applied unit on outputs",
            int'(unit_o), 17);
        chk(samp_en_o == 1'b0, "R8", "enable released after apply", int'(samp_en_o), 0);

        // R9: start and apply pulsed mid-sweep are ignored
        do_apply(0, 0, "R8");
        tgt_unit = 4; acc_pat = 12'h0A4; lat = 6; cal_mode = 1'b1;
        dcnt = done_cnt;
        sb_q.push_back('{ok: 1'b1, err: 1'b0, tmo: 1'b0, sel: 7, unit: 4, req: "R9"});
        @(negedge clk);
        cal_start_i = 1'b1;
        @(negedge clk);
        cal_start_i = 1'b0;
        repeat (12) @(negedge clk);
        chk(busy_o == 1'b1, "R9", "busy mid-sweep", int'(busy_o), 1);
        cal_start_i = 1'b1;
        apply_i = 1'b1;
        apply_sel_i = 4'd2;
        apply_unit_i = 7'd9;
        @(negedge clk);
        cal_start_i = 1'b0;
        apply_i = 1'b0;
        wait_empty();
        repeat (10) @(negedge clk);
        chk(done_cnt - dcnt == 1, "R9", "completions for one sweep", done_cnt - dcnt, 1);
        chk(busy_o == 1'b0, "R9", "idle after sweep", int'(busy_o), 0);
        cal_mode = 1'b0;

        // R1 R2: configuration order seen at the ports over all runs
        chk(viol_en == 0, "R1", "config changes outside enable", viol_en, 0);
        chk(viol_sel == 0, "R2", "select not at top during sweep", viol_sel, 0);
        chk(viol_step == 0, "R2", "unit steps out of order", viol_step, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule